// File: doc/BRIEF.md
# Drain-first subsystem reset controller for a memory-mapped burst port

The block sits on the handshake wires between a bus master and a downstream subsystem and resets that subsystem without ever cutting a burst in half. Normally it passes every valid and ready signal straight through. When a quiesce request arrives, it closes the address channels so no new read or write can start. It lets the work already in flight finish: write data already begun runs to its final beat, every write gets its response, and every read returns its final beat. Only when nothing is left in flight does it pull the subsystem's active-low reset. It holds that reset for a fixed number of cycles, releases it, and then reopens issuance.

Four named states drive the sequence. RUN is pass-through. RUN goes to DRAIN when a quiesce request is sampled. DRAIN goes to RESET once both outstanding counters are zero and no write burst is half sent. RESET goes to RELEASE after the hold period. RELEASE always goes back to RUN, and a one-cycle acknowledge is raised on arrival. There is no way to abort a single transaction; draining and then resetting is the only cancel path. A watchdog on the drain phase can raise a sticky error flag if the drain stalls, but reset is still withheld until the drain completes.

Top module: `qrc_top`

## Requirements
- R1: After `rst_n` is released the block is in RUN: `sub_rst_n` is 1, `quiesce_ack` is 0, `drain_err` is 0, and the address channels pass through (`sub_awvalid` follows `mst_awvalid`, `sub_arvalid` follows `mst_arvalid`).
- R2: From the cycle after a quiesce request is sampled in RUN until RUN is re-entered, `sub_awvalid`, `sub_arvalid`, `mst_awready` and `mst_arready` are held at 0, so no address handshake completes.
- R3: The write count rises on each completed subsystem address-write handshake and falls on each completed response handshake. If both happen in one cycle the count is unchanged. `sub_rst_n` does not fall while the count is non-zero.
- R4: The read count rises on each read-address handshake and falls only on a read-data handshake with `sub_rlast`=1. A beat with `sub_rlast`=0 leaves it unchanged. `sub_rst_n` does not fall while the count is non-zero.
- R5: A write burst whose first beat was accepted without `mst_wlast` stays open until a beat with `mst_wlast`=1 is accepted. Its beats keep passing in DRAIN, and reset waits for it. In DRAIN, when the write count is zero and no burst is open, `sub_wvalid` and `mst_wready` are 0.
- R6: DRAIN moves to RESET on the first clock edge at which both counts are zero and no burst is open. `sub_rst_n` then stays 0 for exactly RESET_CYCLES cycles (16 by default).
- R7: While `sub_rst_n` is 0, `sub_awvalid`, `sub_wvalid`, `sub_arvalid`, `mst_bvalid`, `mst_rvalid`, `mst_awready`, `mst_wready` and `mst_arready` are all 0.
- R8: After reset is released, one RELEASE cycle follows with issuance still closed. In the next cycle the block is in RUN, address issuance is open, and `quiesce_ack` is 1 for that one cycle only.
- R9: A quiesce request seen in DRAIN, RESET or RELEASE is ignored: no second acknowledge follows and RUN stays open.
- R10: When a count equals MAX_OUTST, that channel's address handshake is blocked (`sub_awvalid`/`mst_awready` or `sub_arvalid`/`mst_arready` at 0) until the count falls.
- R11: If DRAIN lasts DRAIN_LIMIT cycles without completing, `drain_err` goes to 1 and stays 1 until `rst_n`. Reset still waits for the drain to complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the controller |
| quiesce_req | input | 1 | Request for a drain-then-reset sequence |
| quiesce_ack | output | 1 | One-cycle pulse when the sequence returns to RUN |
| drain_err | output | 1 | Sticky drain timeout flag |
| sub_rst_n | output | 1 | Active-low reset to the subsystem |
| mst_awvalid | input | 1 | Write address valid from master |
| mst_awready | output | 1 | Write address ready to master |
| sub_awvalid | output | 1 | Write address valid to subsystem |
| sub_awready | input | 1 | Write address ready from subsystem |
| mst_wvalid | input | 1 | Write data valid from master |
| mst_wlast | input | 1 | Final write beat marker from master |
| mst_wready | output | 1 | Write data ready to master |
| sub_wvalid | output | 1 | Write data valid to subsystem |
| sub_wlast | output | 1 | Final write beat marker to subsystem |
| sub_wready | input | 1 | Write data ready from subsystem |
| sub_bvalid | input | 1 | Write response valid from subsystem |
| sub_bready | output | 1 | Write response ready to subsystem |
| mst_bvalid | output | 1 | Write response valid to master |
| mst_bready | input | 1 | Write response ready from master |
| mst_arvalid | input | 1 | Read address valid from master |
| mst_arready | output | 1 | Read address ready to master |
| sub_arvalid | output | 1 | Read address valid to subsystem |
| sub_arready | input | 1 | Read address ready from subsystem |
| sub_rvalid | input | 1 | Read data valid from subsystem |
| sub_rlast | input | 1 | Final read beat marker from subsystem |
| sub_rready | output | 1 | Read data ready to subsystem |
| mst_rvalid | output | 1 | Read data valid to master |
| mst_rlast | output | 1 | Final read beat marker to master |
| mst_rready | input | 1 | Read data ready from master |

## Verification
The assertions check five things on every cycle. No falling edge of `sub_rst_n` occurs while a count is non-zero or a burst is open. Every low phase of `sub_rst_n` lasts exactly the hold period, and all outgoing valids stay low within it. No address handshake completes once a request has been taken in RUN, or while a count is full. The acknowledge never lasts two cycles, and the error flag never clears.

Only the bench scenarios can show the rest. They sweep every mix of zero to three outstanding writes and reads, with and without an open burst. They confirm that reset falls on exactly the edge after the last completion and that issuance reopens exactly one cycle after release. They also show that a non-last read beat or a simultaneous issue-and-complete leaves the drain unfinished, and that requests made during the sequence leave no trace.

// File: rtl/qrc_pkg.sv
package qrc_pkg;
    typedef enum logic [1:0] {
        QS_RUN     = 2'd0,
        QS_DRAIN   = 2'd1,
        QS_RESET   = 2'd2,
        QS_RELEASE = 2'd3
    } qrc_state_e;
endpackage

// File: rtl/qrc_outst_cnt.sv
// Outstanding-transaction counter: up on issue, down on completion.
module qrc_outst_cnt #(
    parameter int MAX_OUTST = 15,
    localparam int CW = $clog2(MAX_OUTST + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    input  logic          dec,
    output logic [CW-1:0] count,
    output logic          is_zero,
    output logic          is_full
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else begin
            unique case ({inc, dec})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    always_comb begin
        is_zero = (count == '0);
        is_full = (count == CW'(MAX_OUTST));
    end
endmodule

// File: rtl/qrc_wburst_track.sv
// Marks a write data burst whose first beat has gone but whose last has not.
module qrc_wburst_track (
    input  logic clk,
    input  logic rst_n,
    input  logic beat,
    input  logic last,
    output logic open
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open <= 1'b0;
        end else if (beat) begin
            open <= !last;
        end
    end
endmodule

// File: rtl/qrc_drain_timer.sv
// Optional watchdog on the drain phase; sets a sticky flag only.
module qrc_drain_timer #(
    parameter int DRAIN_LIMIT = 256,
    parameter bit TMO_EN      = 1'b1,
    localparam int TW = $clog2(DRAIN_LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_drain,
    input  logic drained,
    output logic err
);
    generate
        if (TMO_EN) begin : g_timer
            logic [TW-1:0] elapsed;
            logic          err_q;

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    elapsed <= '0;
                    err_q   <= 1'b0;
                end else if (!in_drain) begin
                    elapsed <= '0;
                end else if (!drained && !err_q) begin
                    if (elapsed == TW'(DRAIN_LIMIT - 1)) begin
                        err_q <= 1'b1;
                    end else begin
                        elapsed <= elapsed + 1'b1;
                    end
                end
            end

            assign err = err_q;
        end else begin : g_no_timer
            logic unused_tmo;
            assign unused_tmo = ^{clk, rst_n, in_drain, drained};
            assign err = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/qrc_seq_fsm.sv
// RUN -> DRAIN -> RESET -> RELEASE -> RUN sequencer.
module qrc_seq_fsm
    import qrc_pkg::*;
#(
    parameter int RESET_CYCLES = 16,
    localparam int HW = $clog2(RESET_CYCLES + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req,
    input  logic       drained,
    output qrc_state_e state,
    output logic       ack,
    output logic       sub_rst_n
);
    qrc_state_e    nxt;
    logic [HW-1:0] hold;
    logic          ack_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= QS_RUN;
            hold  <= '0;
            ack_q <= 1'b0;
        end else begin
            state <= nxt;
            hold  <= (state == QS_RESET) ? hold + 1'b1 : '0;
            ack_q <= (state == QS_RELEASE);
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            QS_RUN:     if (req) nxt = QS_DRAIN;
            QS_DRAIN:   if (drained) nxt = QS_RESET;
            QS_RESET:   if (hold == HW'(RESET_CYCLES - 1)) nxt = QS_RELEASE;
            QS_RELEASE: nxt = QS_RUN;
            default:    nxt = QS_RUN;
        endcase
    end

    always_comb begin
        sub_rst_n = (state != QS_RESET);
        ack       = ack_q;
    end
endmodule

// File: rtl/qrc_top.sv
module qrc_top
    import qrc_pkg::*;
#(
    parameter int MAX_OUTST    = 15,
    parameter int RESET_CYCLES = 16,
    parameter int DRAIN_LIMIT  = 256,
    parameter bit TMO_EN       = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic quiesce_req,
    output logic quiesce_ack,
    output logic drain_err,
    output logic sub_rst_n,
    input  logic mst_awvalid,
    output logic mst_awready,
    output logic sub_awvalid,
    input  logic sub_awready,
    input  logic mst_wvalid,
    input  logic mst_wlast,
    output logic mst_wready,
    output logic sub_wvalid,
    output logic sub_wlast,
    input  logic sub_wready,
    input  logic sub_bvalid,
    output logic sub_bready,
    output logic mst_bvalid,
    input  logic mst_bready,
    input  logic mst_arvalid,
    output logic mst_arready,
    output logic sub_arvalid,
    input  logic sub_arready,
    input  logic sub_rvalid,
    input  logic sub_rlast,
    output logic sub_rready,
    output logic mst_rvalid,
    output logic mst_rlast,
    input  logic mst_rready
);
    localparam int CNT_W = $clog2(MAX_OUTST + 1);

    qrc_state_e     state;
    logic [CNT_W-1:0] wr_cnt, rd_cnt;
    logic           wr_zero, wr_full, rd_zero, rd_full;
    logic           w_open, drained;
    logic           aw_ok, ar_ok, w_ok, resp_ok;
    logic           aw_hs, ar_hs, w_hs, b_hs, rl_hs;

    // channel gating
    always_comb begin
        aw_ok   = (state == QS_RUN) && !wr_full;
        ar_ok   = (state == QS_RUN) && !rd_full;
        w_ok    = (state == QS_RUN) ||
                  ((state == QS_DRAIN) && (w_open || !wr_zero));
        resp_ok = (state == QS_RUN) || (state == QS_DRAIN);

        sub_awvalid = mst_awvalid && aw_ok;
        mst_awready = sub_awready && aw_ok;
        sub_arvalid = mst_arvalid && ar_ok;
        mst_arready = sub_arready && ar_ok;

        sub_wvalid  = mst_wvalid && w_ok;
        sub_wlast   = mst_wlast && w_ok;
        mst_wready  = sub_wready && w_ok;

        mst_bvalid  = sub_bvalid && resp_ok;
        sub_bready  = mst_bready && resp_ok;
        mst_rvalid  = sub_rvalid && resp_ok;
        mst_rlast   = sub_rlast && resp_ok;
        sub_rready  = mst_rready && resp_ok;

        aw_hs = sub_awvalid && sub_awready;
        ar_hs = sub_arvalid && sub_arready;
        w_hs  = sub_wvalid && sub_wready;
        b_hs  = sub_bvalid && sub_bready;
        rl_hs = sub_rvalid && sub_rready && sub_rlast;

        drained = wr_zero && rd_zero && !w_open;
    end

    qrc_outst_cnt #(.MAX_OUTST(MAX_OUTST)) i_wr_cnt (
        .clk(clk), .rst_n(rst_n), .inc(aw_hs), .dec(b_hs),
        .count(wr_cnt), .is_zero(wr_zero), .is_full(wr_full)
    );

    qrc_outst_cnt #(.MAX_OUTST(MAX_OUTST)) i_rd_cnt (
        .clk(clk), .rst_n(rst_n), .inc(ar_hs), .dec(rl_hs),
        .count(rd_cnt), .is_zero(rd_zero), .is_full(rd_full)
    );

    qrc_wburst_track i_wtrk (
        .clk(clk), .rst_n(rst_n), .beat(w_hs), .last(sub_wlast), .open(w_open)
    );

    qrc_drain_timer #(.DRAIN_LIMIT(DRAIN_LIMIT), .TMO_EN(TMO_EN)) i_tmo (
        .clk(clk), .rst_n(rst_n), .in_drain(state == QS_DRAIN),
        .drained(drained), .err(drain_err)
    );

    qrc_seq_fsm #(.RESET_CYCLES(RESET_CYCLES)) i_fsm (
        .clk(clk), .rst_n(rst_n), .req(quiesce_req), .drained(drained),
        .state(state), .ack(quiesce_ack), .sub_rst_n(sub_rst_n)
    );
endmodule

// File: rtl/qrc_checker.sv
module qrc_checker
    import qrc_pkg::*;
#(
    parameter int MAX_OUTST    = 15,
    parameter int RESET_CYCLES = 16,
    localparam int CNT_W = $clog2(MAX_OUTST + 1),
    localparam int LW    = $clog2(RESET_CYCLES + 2) + 1
) (
    input logic             clk,
    input logic             rst_n,
    input qrc_state_e       state,
    input logic [CNT_W-1:0] wr_cnt,
    input logic [CNT_W-1:0] rd_cnt,
    input logic             w_open,
    input logic             quiesce_req,
    input logic             quiesce_ack,
    input logic             drain_err,
    input logic             sub_rst_n,
    input logic             sub_awvalid,
    input logic             sub_awready,
    input logic             sub_arvalid,
    input logic             sub_arready,
    input logic             sub_wvalid,
    input logic             mst_bvalid,
    input logic             mst_rvalid
);
    logic [LW-1:0] low_run;

    always_ff @(posedge clk) begin
        if (!rst_n) low_run <= '0;
        else if (!sub_rst_n) low_run <= low_run + 1'b1;
        else low_run <= '0;
    end

    p_gate_after_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (quiesce_req && state == QS_RUN) |=> (!sub_awvalid && !sub_arvalid));

    p_no_rst_writes_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sub_rst_n) |-> ($past(wr_cnt) == '0));

    p_no_rst_reads_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sub_rst_n) |-> ($past(rd_cnt) == '0));

    p_no_rst_open_burst_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sub_rst_n) |-> !$past(w_open));

    p_rst_length_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sub_rst_n) |-> (low_run == LW'(RESET_CYCLES)));

    p_quiet_in_reset_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !sub_rst_n |-> (!sub_awvalid && !sub_wvalid && !sub_arvalid &&
                        !mst_bvalid && !mst_rvalid));

    p_ack_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        quiesce_ack |=> !quiesce_ack);

    p_wr_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sub_awvalid && sub_awready) |-> (wr_cnt != CNT_W'(MAX_OUTST)));

    p_rd_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sub_arvalid && sub_arready) |-> (rd_cnt != CNT_W'(MAX_OUTST)));

    p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        drain_err |=> drain_err);
endmodule

bind qrc_top qrc_checker #(.MAX_OUTST(MAX_OUTST), .RESET_CYCLES(RESET_CYCLES)) i_qrc_checker (
    .clk(clk), .rst_n(rst_n), .state(state), .wr_cnt(wr_cnt), .rd_cnt(rd_cnt),
    .w_open(w_open), .quiesce_req(quiesce_req), .quiesce_ack(quiesce_ack),
    .drain_err(drain_err), .sub_rst_n(sub_rst_n), .sub_awvalid(sub_awvalid),
    .sub_awready(sub_awready), .sub_arvalid(sub_arvalid), .sub_arready(sub_arready),
    .sub_wvalid(sub_wvalid), .mst_bvalid(mst_bvalid), .mst_rvalid(mst_rvalid)
);

// File: tb/test_qrc_top.sv
module test_qrc_top;
    localparam int CLK_PERIOD = 10;
    localparam int MAXO  = 3;
    localparam int RSTC  = 16;
    localparam int DLIM  = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic quiesce_req = 1'b0;
    logic quiesce_ack, drain_err, sub_rst_n;
    logic mst_awvalid = 1'b0, sub_awready = 1'b0, mst_awready, sub_awvalid;
    logic mst_wvalid = 1'b0, mst_wlast = 1'b0, sub_wready = 1'b0;
    logic mst_wready, sub_wvalid, sub_wlast;
    logic sub_bvalid = 1'b0, mst_bready = 1'b0, sub_bready, mst_bvalid;
    logic mst_arvalid = 1'b0, sub_arready = 1'b0, mst_arready, sub_arvalid;
    logic sub_rvalid = 1'b0, sub_rlast = 1'b0, mst_rready = 1'b0;
    logic sub_rready, mst_rvalid, mst_rlast;

    int nvec = 0;
    int nbad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    qrc_top #(.MAX_OUTST(MAXO), .RESET_CYCLES(RSTC), .DRAIN_LIMIT(DLIM), .TMO_EN(1'b1)) i_qrc_top (
        .clk(clk), .rst_n(rst_n), .quiesce_req(quiesce_req), .quiesce_ack(quiesce_ack),
        .drain_err(drain_err), .sub_rst_n(sub_rst_n),
        .mst_awvalid(mst_awvalid), .mst_awready(mst_awready),
        .sub_awvalid(sub_awvalid), .sub_awready(sub_awready),
        .mst_wvalid(mst_wvalid), .mst_wlast(mst_wlast), .mst_wready(mst_wready),
        .sub_wvalid(sub_wvalid), .sub_wlast(sub_wlast), .sub_wready(sub_wready),
        .sub_bvalid(sub_bvalid), .sub_bready(sub_bready),
        .mst_bvalid(mst_bvalid), .mst_bready(mst_bready),
        .mst_arvalid(mst_arvalid), .mst_arready(mst_arready),
        .sub_arvalid(sub_arvalid), .sub_arready(sub_arready),
        .sub_rvalid(sub_rvalid), .sub_rlast(sub_rlast), .sub_rready(sub_rready),
        .mst_rvalid(mst_rvalid), .mst_rlast(mst_rlast), .mst_rready(mst_rready)
    );

    task automatic check(string req, int act, int exp);
        nvec++;
        if (act != exp) begin
            nbad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic hs_aw();
        mst_awvalid = 1'b1; sub_awready = 1'b1;
        @(negedge clk);
        mst_awvalid = 1'b0; sub_awready = 1'b0;
    endtask

    task automatic hs_ar();
        mst_arvalid = 1'b1; sub_arready = 1'b1;
        @(negedge clk);
        mst_arvalid = 1'b0; sub_arready = 1'b0;
    endtask

    task automatic hs_w(bit last);
        mst_wvalid = 1'b1; mst_wlast = last; sub_wready = 1'b1;
        @(negedge clk);
        mst_wvalid = 1'b0; mst_wlast = 1'b0; sub_wready = 1'b0;
    endtask

    task automatic hs_b();
        sub_bvalid = 1'b1; mst_bready = 1'b1;
        @(negedge clk);
        sub_bvalid = 1'b0; mst_bready = 1'b0;
    endtask

    task automatic hs_r(bit last);
        sub_rvalid = 1'b1; sub_rlast = last; mst_rready = 1'b1;
        @(negedge clk);
        sub_rvalid = 1'b0; sub_rlast = 1'b0; mst_rready = 1'b0;
    endtask

    task automatic req_pulse();
        quiesce_req = 1'b1;
        @(negedge clk);
        quiesce_req = 1'b0;
    endtask

    // Called at the negedge of the first cycle with sub_rst_n low.
    task automatic reset_tail();
        int low;
        low = 1;
        mst_awvalid = 1'b1; sub_awready = 1'b1; mst_wvalid = 1'b1; sub_wready = 1'b1;
        mst_arvalid = 1'b1; sub_arready = 1'b1; sub_bvalid = 1'b1; sub_rvalid = 1'b1;
        quiesce_req = 1'b1;
        #1;
        check("R7 sub_awvalid in reset", int'(sub_awvalid), 0);
        check("R7 sub_wvalid in reset", int'(sub_wvalid), 0);
        check("R7 sub_arvalid in reset", int'(sub_arvalid), 0);
        check("R7 mst_bvalid in reset", int'(mst_bvalid), 0);
        check("R7 mst_rvalid in reset", int'(mst_rvalid), 0);
        check("R7 readies in reset", int'({mst_awready, mst_wready, mst_arready}), 0);
        @(negedge clk);
        mst_awvalid = 1'b0; sub_awready = 1'b0; mst_wvalid = 1'b0; sub_wready = 1'b0;
        mst_arvalid = 1'b0; sub_arready = 1'b0; sub_bvalid = 1'b0; sub_rvalid = 1'b0;
        quiesce_req = 1'b0;
        while (!sub_rst_n && low < 64) begin
            low++;
            @(negedge clk);
        end
        check("R6 reset low cycles", low, RSTC);
        // RELEASE cycle
        check("R8 no ack in release", int'(quiesce_ack), 0);
        quiesce_req = 1'b1;
        mst_awvalid = 1'b1;
        #1;
        check("R8 issuance closed in release", int'(sub_awvalid), 0);
        @(negedge clk);
        quiesce_req = 1'b0;
        check("R8 ack on RUN return", int'(quiesce_ack), 1);
        check("R8 issuance reopened", int'(sub_awvalid), 1);
        mst_awvalid = 1'b0;
        @(negedge clk);
        check("R8 ack one cycle", int'(quiesce_ack), 0);
        mst_arvalid = 1'b1;
        #1;
        check("R9 late request ignored, reads open", int'(sub_arvalid), 1);
        check("R9 late request ignored, no reset", int'(sub_rst_n), 1);
        mst_arvalid = 1'b0;
        @(negedge clk);
        check("R9 no second ack", int'(quiesce_ack), 0);
    endtask

    task automatic scenario(int nw, int nr, bit op);
        for (int i = 0; i < nw; i++) hs_aw();
        for (int i = 0; i < nr; i++) hs_ar();
        if (op) hs_w(1'b0);
        req_pulse();
        mst_awvalid = 1'b1; sub_awready = 1'b1; mst_arvalid = 1'b1; sub_arready = 1'b1;
        #1;
        check("R2 sub_awvalid gated", int'(sub_awvalid), 0);
        check("R2 mst_awready gated", int'(mst_awready), 0);
        check("R2 sub_arvalid gated", int'(sub_arvalid), 0);
        check("R2 mst_arready gated", int'(mst_arready), 0);
        mst_awvalid = 1'b0; sub_awready = 1'b0; mst_arvalid = 1'b0; sub_arready = 1'b0;
        if (nw == 0 && !op && nr > 0) begin
            mst_wvalid = 1'b1; sub_wready = 1'b1;
            #1;
            check("R5 W blocked when nothing owed", int'(sub_wvalid), 0);
            check("R5 wready blocked when nothing owed", int'(mst_wready), 0);
            mst_wvalid = 1'b0; sub_wready = 1'b0;
        end
        if (op) begin
            check("R5 no reset with open burst", int'(sub_rst_n), 1);
            mst_wvalid = 1'b1; mst_wlast = 1'b1; sub_wready = 1'b1;
            #1;
            check("R5 last beat passes in drain", int'(sub_wvalid), 1);
            @(negedge clk);
            mst_wvalid = 1'b0; mst_wlast = 1'b0; sub_wready = 1'b0;
        end
        for (int i = 0; i < nw; i++) begin
            check("R3 no reset while writes owed", int'(sub_rst_n), 1);
            hs_b();
        end
        for (int i = 0; i < nr; i++) begin
            if (i == 0) begin
                hs_r(1'b0);
                check("R4 non-last beat keeps read owed", int'(sub_rst_n), 1);
            end
            check("R4 no reset while reads owed", int'(sub_rst_n), 1);
            hs_r(1'b1);
        end
        check("R6 reset not yet on last completion", int'(sub_rst_n), 1);
        @(negedge clk);
        check("R6 reset on edge after drain", int'(sub_rst_n), 0);
        reset_tail();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            nbad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 sub_rst_n", int'(sub_rst_n), 1);
        check("R1 quiesce_ack", int'(quiesce_ack), 0);
        check("R1 drain_err", int'(drain_err), 0);
        mst_awvalid = 1'b1; mst_arvalid = 1'b1;
        #1;
        check("R1 aw pass", int'(sub_awvalid), 1);
        check("R1 ar pass", int'(sub_arvalid), 1);
        mst_awvalid = 1'b0; mst_arvalid = 1'b0;
        #1;
        check("R1 aw follows low", int'(sub_awvalid), 0);
        @(negedge clk);

        // sweep
        for (int nw = 0; nw <= MAXO; nw++)
            for (int nr = 0; nr <= MAXO; nr++)
                for (int op = 0; op < 2; op++)
                    scenario(nw, nr, op[0]);

        // R3 simultaneous issue and completion leaves count unchanged
        hs_aw();
        mst_awvalid = 1'b1; sub_awready = 1'b1; sub_bvalid = 1'b1; mst_bready = 1'b1;
        @(negedge clk);
        mst_awvalid = 1'b0; sub_awready = 1'b0; sub_bvalid = 1'b0; mst_bready = 1'b0;
        req_pulse();
        @(negedge clk);
        check("R3 simultaneous inc/dec keeps one owed", int'(sub_rst_n), 1);
        hs_b();
        check("R3 reset waits edge after last B", int'(sub_rst_n), 1);
        @(negedge clk);
        check("R3 reset after count reaches zero", int'(sub_rst_n), 0);
        reset_tail();

        // R10 full counters block issuance
        for (int i = 0; i < MAXO; i++) hs_aw();
        for (int i = 0; i < MAXO; i++) hs_ar();
        mst_awvalid = 1'b1; sub_awready = 1'b1; mst_arvalid = 1'b1; sub_arready = 1'b1;
        #1;
        check("R10 aw blocked when full", int'(sub_awvalid), 0);
        check("R10 awready blocked when full", int'(mst_awready), 0);
        check("R10 ar blocked when full", int'(sub_arvalid), 0);
        check("R10 arready blocked when full", int'(mst_arready), 0);
        mst_awvalid = 1'b0; sub_awready = 1'b0; mst_arvalid = 1'b0; sub_arready = 1'b0;
        hs_b();
        hs_r(1'b1);
        mst_awvalid = 1'b1; mst_arvalid = 1'b1;
        #1;
        check("R10 aw open after one completes", int'(sub_awvalid), 1);
        check("R10 ar open after one completes", int'(sub_arvalid), 1);
        mst_awvalid = 1'b0; mst_arvalid = 1'b0;
        for (int i = 1; i < MAXO; i++) begin hs_b(); hs_r(1'b1); end

        // R11 drain timeout
        hs_aw();
        req_pulse();
        repeat (DLIM - 1) @(negedge clk);
        check("R11 no error before limit", int'(drain_err), 0);
        @(negedge clk);
        check("R11 error at limit", int'(drain_err), 1);
        check("R11 reset still withheld", int'(sub_rst_n), 1);
        repeat (3) @(negedge clk);
        check("R11 reset withheld later", int'(sub_rst_n), 1);
        hs_b();
        @(negedge clk);
        check("R11 reset after late drain", int'(sub_rst_n), 0);
        reset_tail();
        check("R11 error sticky", int'(drain_err), 1);

        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 error cleared by rst_n", int'(drain_err), 0);
        check("R1 sub_rst_n after rst_n", int'(sub_rst_n), 1);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule